// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an operand specifier into the address that the operand lives at. A caller presents a 3-bit mode code, a 16-bit address field, the value of the selected register, the program counter and a base register, and pulses `start`. The unit samples everything on that edge and raises `busy`. One or more cycles later it pulses `done` for one cycle. During that cycle the effective address is on `ea`. For the autoincrementing mode, a register write-back (`wb_en`, `wb_data`) is also presented.

Register indirect, displacement, PC-relative and scaled-index modes are pure arithmetic and finish in the cycle after `start`. Two modes need a word from memory: indirect with the index added first, and indirect with the index added afterwards. For these the unit drives a simple read port (`rd_req`, `rd_addr`) and waits for `rd_valid`, which costs at least one extra cycle. The address field is sign-extended wherever it acts as a signed offset. It is zero-extended wherever it acts as an absolute location.

Top module: `eag_unit`

## Requirements
- R1: After reset, and until the first `start`, `busy`, `done`, `rd_req`, `wb_en` and `err` are all low.
- R2: Mode 0 (register through pointer) gives `ea` = `reg_val`. `done` rises in the cycle right after the `start` edge.
- R3: Mode 1 (offset from register) gives `ea` = sign-extended `afield` + `reg_val`, modulo 2^32, with `done` in the cycle after `start`.
- R4: Mode 2 (PC-relative) gives `ea` = sign-extended `afield` + `pc`, with `done` in the cycle after `start`.
- R5: Mode 3 (scaled index) gives `ea` = `base_val` + (`reg_val` << `scale_sel`) + sign-extended `afield`. `scale_sel` values 0, 1, 2 and 3 select element sizes 1, 2, 4 and 8. `done` comes in the cycle after `start`.
- R6: Mode 4 (autoincrement) gives `ea` = zero-extended `afield` + `reg_val`. In the `done` cycle, `wb_en` is high and `wb_data` = `reg_val` + 1. In every other mode `wb_en` stays low.
- R7: Mode 5 (index, then indirect) raises `rd_req` with `rd_addr` = zero-extended `afield` + `reg_val`. The returned word becomes `ea` unchanged.
- R8: Mode 6 (indirect, then index) raises `rd_req` with `rd_addr` = zero-extended `afield`. `ea` = returned word + `reg_val`, using the `reg_val` sampled at `start`.
- R9: In modes 5 and 6, `rd_req` rises in the cycle after `start`. It then holds with a steady `rd_addr` until a cycle in which `rd_valid` is high. `rd_data` is taken in that same cycle, and `done` follows in the next cycle. The total latency is therefore 2 + N cycles when `rd_valid` arrives N cycles after `rd_req` rises.
- R10: `done` lasts exactly one cycle. `busy` is high from the cycle after `start` through the `done` cycle, and low in the cycle after `done`.
- R11: Mode 7 is unsupported. It completes with `done` in the cycle after `start`, with `err` high and `wb_en` low. `err` is low for modes 0 to 6 and outside `done`.
- R12: A `start` pulse seen while `busy` is high is ignored. The operation in flight finishes with its own operands and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (accepted only when not busy) |
| mode | input | 3 | Addressing mode code, 0 to 7 |
| afield | input | 16 | Address field from the instruction |
| reg_val | input | 32 | Selected register / index register value |
| pc | input | 32 | Program counter |
| base_val | input | 32 | Base register value for scaled-index mode |
| scale_sel | input | 2 | Index scale as a shift count (x1, x2, x4, x8) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 32 | Effective address, valid while done is high |
| err | output | 1 | Unsupported mode, valid while done is high |
| wb_en | output | 1 | Register write-back request for autoincrement |
| wb_data | output | 32 | Incremented register value |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |

## Verification
The hardest situation to reach is a new `start` arriving while an indirect read is still pending. The unit must ignore it and keep the sampled index for the post-added mode. The stimulus reaches this with a memory responder whose delay is programmable. With a two-cycle delay it pulses `start` with different operands on every wait cycle, then checks the final address against the first request. The sweep also covers every mode with sign-boundary address fields (0x7FFF, 0x8000, 0xFFFC), all four scales and read delays of zero to two cycles. This exercises wrap-around sums and a zero-wait response that arrives in the first request cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    M_REGIND  = 3'd0,
    M_DISP    = 3'd1,
    M_PCREL   = 3'd2,
    M_SCALED  = 3'd3,
    M_AUTOINC = 3'd4,
    M_PREIND  = 3'd5,
    M_POSTIND = 3'd6,
    M_RSVD    = 3'd7
  } eag_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_FIN   = 2'd2
  } eag_state_e;

  function automatic logic mode_fetches(eag_mode_e m);
    return (m == M_PREIND) || (m == M_POSTIND);
  endfunction

endpackage

// File: rtl/eag_ext.sv
module eag_ext #(
  parameter int FW = 16,
  parameter int AW = 32
) (
  input  logic [FW-1:0] fld,
  output logic [AW-1:0] fld_s,
  output logic [AW-1:0] fld_z
);
  localparam int PADW = AW - FW;

  assign fld_s = {{PADW{fld[FW-1]}}, fld};
  assign fld_z = {{PADW{1'b0}}, fld};
endmodule

// File: rtl/eag_scale.sv
module eag_scale #(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic [AW-1:0]  idx,
  input  logic [SCW-1:0] sel,
  output logic [AW-1:0]  scaled
);
  localparam int NSC = 1 << SCW;

  logic [AW-1:0] cand [NSC];

  for (genvar g = 0; g < NSC; g++) begin : g_shift
    assign cand[g] = idx << g;
  end

  assign scaled = cand[sel];
endmodule

// File: rtl/eag_fsm.sv
module eag_fsm
  import eag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_fetch,
  input  logic rd_valid,
  output logic busy,
  output logic done,
  output logic rd_req,
  output logic cap_start,
  output logic cap_rd
);
  eag_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_n = need_fetch ? ST_FETCH : ST_FIN;
      ST_FETCH: if (rd_valid) st_n = ST_FIN;
      ST_FIN:   st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign rd_req    = (st_q == ST_FETCH);
  assign cap_start = (st_q == ST_IDLE) && start;
  assign cap_rd    = (st_q == ST_FETCH) && rd_valid;
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FW  = 16,
  parameter int SCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [FW-1:0]  afield,
  input  logic [AW-1:0]  reg_val,
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  base_val,
  input  logic [SCW-1:0] scale_sel,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  ea,
  output logic           err,
  output logic           wb_en,
  output logic [AW-1:0]  wb_data,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_data
);
  eag_mode_e     mode_e;
  logic [AW-1:0] fld_s, fld_z, idx_sc;
  logic [AW-1:0] ea_calc, rda_calc, idx_calc;
  logic          cap_start, cap_rd;

  logic [AW-1:0] ea_q, wb_q, rda_q, idx_q;
  logic          err_q, wbe_q;

  assign mode_e = eag_mode_e'(mode);

  eag_ext #(.FW(FW), .AW(AW)) u_ext (
    .fld   (afield),
    .fld_s (fld_s),
    .fld_z (fld_z)
  );

  eag_scale #(.AW(AW), .SCW(SCW)) u_scale (
    .idx    (reg_val),
    .sel    (scale_sel),
    .scaled (idx_sc)
  );

  eag_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .need_fetch (mode_fetches(mode_e)),
    .rd_valid   (rd_valid),
    .busy       (busy),
    .done       (done),
    .rd_req     (rd_req),
    .cap_start  (cap_start),
    .cap_rd     (cap_rd)
  );

  // Arithmetic result for the modes that need no memory word
  always_comb begin
    case (mode_e)
      M_REGIND:  ea_calc = reg_val;
      M_DISP:    ea_calc = fld_s + reg_val;
      M_PCREL:   ea_calc = fld_s + pc;
      M_SCALED:  ea_calc = base_val + idx_sc + fld_s;
      M_AUTOINC: ea_calc = fld_z + reg_val;
      default:   ea_calc = '0;
    endcase
  end

  // Fetch address and the term added to the fetched word
  always_comb begin
    if (mode_e == M_POSTIND) begin
      rda_calc = fld_z;
      idx_calc = reg_val;
    end else begin
      rda_calc = fld_z + reg_val;
      idx_calc = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      wb_q  <= '0;
      rda_q <= '0;
      idx_q <= '0;
      err_q <= 1'b0;
      wbe_q <= 1'b0;
    end else if (cap_start) begin
      ea_q  <= ea_calc;
      wb_q  <= reg_val + 1'b1;
      rda_q <= rda_calc;
      idx_q <= idx_calc;
      err_q <= (mode_e == M_RSVD);
      wbe_q <= (mode_e == M_AUTOINC);
    end else if (cap_rd) begin
      ea_q  <= rd_data + idx_q;
    end
  end

  assign ea      = ea_q;
  assign err     = err_q & done;
  assign wb_en   = wbe_q & done;
  assign wb_data = wb_q;
  assign rd_addr = rda_q;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int AW  = 32,
  parameter int FW  = 16,
  parameter int SCW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2:0]     mode,
  input logic [FW-1:0]  afield,
  input logic [AW-1:0]  reg_val,
  input logic [AW-1:0]  pc,
  input logic [AW-1:0]  base_val,
  input logic [SCW-1:0] scale_sel,
  input logic           busy,
  input logic           done,
  input logic [AW-1:0]  ea,
  input logic           err,
  input logic           wb_en,
  input logic [AW-1:0]  wb_data,
  input logic           rd_req,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_valid,
  input logic [AW-1:0]  rd_data
);
  logic fetch_mode;
  assign fetch_mode = (mode == 3'd5) || (mode == 3'd6);

  p_fast_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !fetch_mode) |=> done);

  p_wb_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_fetch_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && fetch_mode) |=> (rd_req && !done));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  p_rd_to_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (done && !rd_req));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_err_no_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !wb_en));

  p_busy_stays_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind eag_unit eag_unit_chk #(.AW(AW), .FW(FW), .SCW(SCW)) u_chk (.*);

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
  logic        clk, rst_n, start;
  logic [2:0]  mode;
  logic [15:0] afield;
  logic [31:0] reg_val, pc, base_val;
  logic [1:0]  scale_sel;
  logic        busy, done, err, wb_en, rd_req, rd_valid;
  logic [31:0] ea, wb_data, rd_addr, rd_data;

  int checks = 0;
  int errors = 0;
  int mem_dly = 0;

  eag_unit u_eag_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
    .reg_val(reg_val), .pc(pc), .base_val(base_val), .scale_sel(scale_sel),
    .busy(busy), .done(done), .ea(ea), .err(err), .wb_en(wb_en),
    .wb_data(wb_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] a);
    return {{16{a[15]}}, a};
  endfunction

  function automatic logic [31:0] zx(input logic [15:0] a);
    return {16'h0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder: answers rd_req after mem_dly wait cycles
  initial begin
    int cnt;
    cnt = 0;
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        if (cnt >= mem_dly) begin
          rd_valid = 1'b1;
          rd_data  = mem_word(rd_addr);
        end else begin
          rd_valid = 1'b0;
          cnt++;
        end
      end else begin
        cnt = 0;
        rd_valid = 1'b0;
      end
    end
  end

  task automatic run_op(input logic [2:0] m, input logic [15:0] a,
                        input logic [31:0] r, input logic [31:0] p,
                        input logic [31:0] b, input logic [1:0] sc,
                        input int dly, input bit interfere);
    logic [31:0] exp_ea, exp_ra;
    bit is_mem, exp_err, exp_wbe;
    int lat, cnt;
    string rq;
    is_mem  = (m == 3'd5) || (m == 3'd6);
    exp_err = (m == 3'd7);
    exp_wbe = (m == 3'd4);
    exp_ra  = (m == 3'd6) ? zx(a) : zx(a) + r;
    case (m)
      3'd0: begin exp_ea = r;                     rq = "R2"; end
      3'd1: begin exp_ea = sx(a) + r;             rq = "R3"; end
      3'd2: begin exp_ea = sx(a) + p;             rq = "R4"; end
      3'd3: begin exp_ea = b + (r << sc) + sx(a); rq = "R5"; end
      3'd4: begin exp_ea = zx(a) + r;             rq = "R6"; end
      3'd5: begin exp_ea = mem_word(exp_ra);      rq = "R7"; end
      3'd6: begin exp_ea = mem_word(exp_ra) + r;  rq = "R8"; end
      default: begin exp_ea = '0;                 rq = "R11"; end
    endcase
    lat = is_mem ? 2 + dly : 1;

    @(negedge clk);
    mem_dly = dly;
    mode = m; afield = a; reg_val = r; pc = p; base_val = b; scale_sel = sc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 40) begin
      if (is_mem && cnt == 1) begin
        chk(rd_req == 1'b1, "R9", "rd_req after start", 32'(rd_req), 32'd1);
        chk(rd_addr == exp_ra, is_mem && m == 3'd6 ? "R8" : "R7",
            "rd_addr", rd_addr, exp_ra);
      end
      if (interfere) begin
        start = 1'b1; mode = 3'd0; reg_val = ~r; afield = ~a;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == lat, is_mem ? "R9" : rq, "latency", 32'(cnt), 32'(lat));
    if (!exp_err)
      chk(ea == exp_ea, interfere ? "R12" : rq, "ea", ea, exp_ea);
    chk(err == exp_err, "R11", "err", 32'(err), 32'(exp_err));
    chk(wb_en == exp_wbe, "R6", "wb_en", 32'(wb_en), 32'(exp_wbe));
    if (exp_wbe)
      chk(wb_data == r + 32'd1, "R6", "wb_data", wb_data, r + 32'd1);
    chk(busy == 1'b1, "R10", "busy at done", 32'(busy), 32'd1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done/busy after done",
        {30'd0, done, busy}, 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] pa;
    logic [31:0] pr, pp, pb;
    rst_n = 1'b0; start = 1'b0; mode = '0; afield = '0; reg_val = '0;
    pc = '0; base_val = '0; scale_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, rd_req, wb_en, err} == 5'b0, "R1", "idle after reset",
        {27'd0, busy, done, rd_req, wb_en, err}, 32'd0);

    for (int m = 0; m < 8; m++) begin
      for (int pt = 0; pt < 4; pt++) begin
        case (pt)
          0: begin pa = 16'h0004; pr = 32'h0000_1000; pp = 32'h0000_2000; pb = 32'h0001_0000; end
          1: begin pa = 16'hFFFC; pr = 32'h0000_0010; pp = 32'h8000_0000; pb = 32'h00FF_0000; end
          2: begin pa = 16'h8000; pr = 32'hFFFF_FFFF; pp = 32'h0000_0100; pb = 32'h1234_5678; end
          default: begin pa = 16'h7FFF; pr = 32'h4000_0001; pp = 32'hFFFF_FFF0; pb = 32'h0; end
        endcase
        for (int sc = 0; sc < 4; sc++) begin
          for (int d = 0; d < 3; d++) begin
            run_op(3'(m), pa, pr, pp, pb, 2'(sc), d, (d == 2) && (sc == 1));
          end
        end
      end
    end
    finish_run();
  end
endmodule